// File: doc/BRIEF.md
# Byte-Wide Command Register Bank with Coherent Word Readback

This block is the host-facing register bank of a position-output peripheral that sits on an 8-bit I/O bus. It claims a window of 32 byte addresses whose upper address bits are compared against a five-bit switch setting. The window holds four 16-bit command settings: position, output frequency, excitation voltage and transformation ratio. Each setting is written as a low/high byte pair and drives the analog side as a full word. The window also holds a live 16-bit readback word from the output stage, three status bytes and four read-only identity words.

An 8-bit bus cannot move a word in one access. The block handles this in both directions. A low-byte write is staged in a shadow byte, and the whole word is committed only when the high byte arrives. A high-byte read of the live readback word captures the matching low byte, and the following low-byte read returns that captured byte, so the two halves always come from one sample. After reset every command output is zero except the frequency word, which starts at 360. The excitation enable stays off until a nonzero voltage code is committed.

Top module: `posio_regs`

## Requirements
- R1: An access is taken only when bus_addr[9:5] equals base_sw, where a switch reading 1 (off) stands for an address bit of 1. bus_addr[4:0] is the offset. An access outside the window leaves all state unchanged, and its read data is 0x00.
- R2: After reset, pos_cmd, volt_cmd and ratio_cmd are 0x0000, freq_cmd is 360 (0x0168) and exc_en is 0.
- R3: Writing offset 0x00, 0x06, 0x08 or 0x0A stages a low byte for position, frequency, voltage or ratio respectively, and does not change that output. Writing offset 0x01, 0x07, 0x09 or 0x0B commits {written byte, staged byte} to the same output on the next clock edge.
- R4: Reading a setting's even offset returns bits 7:0 of its committed word, and reading its odd offset returns bits 15:8. Frequency is in Hz and voltage uses a 0.1 Vrms step.
- R5: Reading offset 0x03 returns wrap_val[15:8] and captures wrap_val[7:0]. The next read of offset 0x02 returns the captured byte even if wrap_val has changed since, and releases the capture. Reading 0x02 with no capture pending returns the live wrap_val[7:0].
- R6: Offset 0x04 returns acc_ok in bit 0. Offset 0x16 returns sig_ok[1:0] in bits 1:0. Offset 0x18 returns exc_ok in bit 0. All other bits of these bytes read 0.
- R7: Offsets 0x0C/0x0D return the model word, 0x10/0x11 the serial word, 0x12/0x13 the date word and 0x14/0x15 the revision word, each as low/high bytes of its parameter.
- R8: Writes to read-only offsets (0x02–0x04, 0x0C–0x0D, 0x10–0x16, 0x18) and to unmapped offsets change no output and no staged byte. Reads of unmapped offsets return 0x00.
- R9: exc_en becomes 1 when a nonzero voltage code is committed and 0 when a zero code is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sw | input | 5 | Base switch setting, compared with address bits 9:5 |
| bus_addr | input | 10 | I/O byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, valid in the cycle bus_rd is high |
| wrap_val | input | 16 | Live readback word from the output stage |
| acc_ok | input | 1 | Accuracy self-test result |
| sig_ok | input | 2 | Signal presence flags for the two outputs |
| exc_ok | input | 1 | Excitation presence flag |
| pos_cmd | output | 16 | Committed position command |
| freq_cmd | output | 16 | Committed excitation frequency in Hz |
| volt_cmd | output | 16 | Committed excitation voltage, 0.1 Vrms per step |
| ratio_cmd | output | 16 | Committed transformation ratio |
| exc_en | output | 1 | Excitation output enable |

## Verification
Every setting is written low-then-high with distinct byte values. Each output is checked after the low write, where it must not move, and again after the high write, which separates staging from committing and shows byte order. The coherent readback is tested by changing wrap_val between the two halves of a read, so the captured byte is seen to differ from the live one. A low read with no capture pending is also tested, to show that the capture is released and not left latched. Writes that miss the window, and writes to read-only offsets, are placed between a staged low byte and its commit, so any corruption of the staged byte shows up in the committed word. The voltage word is committed as nonzero and then as zero, to show the enable follows the code both ways.

// File: rtl/posio_regs.sv
module posio_regs #(
  parameter logic [15:0] MODEL_ID   = 16'h0A51,
  parameter logic [15:0] SERIAL_NO  = 16'h1C07,
  parameter logic [15:0] DATE_CODE  = 16'h2419,
  parameter logic [15:0] REV_LEVEL  = 16'h0004,
  parameter logic [15:0] FREQ_RESET = 16'd360
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  base_sw,
  input  logic [9:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [15:0] wrap_val,
  input  logic        acc_ok,
  input  logic [1:0]  sig_ok,
  input  logic        exc_ok,
  output logic [15:0] pos_cmd,
  output logic [15:0] freq_cmd,
  output logic [15:0] volt_cmd,
  output logic [15:0] ratio_cmd,
  output logic        exc_en
);

  localparam logic [4:0] OFS_POS_LO  = 5'h00;
  localparam logic [4:0] OFS_POS_HI  = 5'h01;
  localparam logic [4:0] OFS_WRP_LO  = 5'h02;
  localparam logic [4:0] OFS_WRP_HI  = 5'h03;
  localparam logic [4:0] OFS_ACC     = 5'h04;
  localparam logic [4:0] OFS_FRQ_LO  = 5'h06;
  localparam logic [4:0] OFS_FRQ_HI  = 5'h07;
  localparam logic [4:0] OFS_VLT_LO  = 5'h08;
  localparam logic [4:0] OFS_VLT_HI  = 5'h09;
  localparam logic [4:0] OFS_RAT_LO  = 5'h0A;
  localparam logic [4:0] OFS_RAT_HI  = 5'h0B;
  localparam logic [4:0] OFS_MOD_LO  = 5'h0C;
  localparam logic [4:0] OFS_MOD_HI  = 5'h0D;
  localparam logic [4:0] OFS_SER_LO  = 5'h10;
  localparam logic [4:0] OFS_SER_HI  = 5'h11;
  localparam logic [4:0] OFS_DAT_LO  = 5'h12;
  localparam logic [4:0] OFS_DAT_HI  = 5'h13;
  localparam logic [4:0] OFS_REV_LO  = 5'h14;
  localparam logic [4:0] OFS_REV_HI  = 5'h15;
  localparam logic [4:0] OFS_SIG     = 5'h16;
  localparam logic [4:0] OFS_EXC     = 5'h18;

  logic       hit;
  logic [4:0] offs;
  logic       wr_hit, rd_hit;
  logic [7:0] pos_stg, frq_stg, vlt_stg, rat_stg;
  logic [7:0] hold_q;
  logic       held_q;

  assign hit    = (bus_addr[9:5] == base_sw);
  assign offs   = bus_addr[4:0];
  assign wr_hit = bus_wr & hit;
  assign rd_hit = bus_rd & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_cmd   <= 16'h0000;
      freq_cmd  <= FREQ_RESET;
      volt_cmd  <= 16'h0000;
      ratio_cmd <= 16'h0000;
      exc_en    <= 1'b0;
      pos_stg   <= 8'h00;
      frq_stg   <= FREQ_RESET[7:0];
      vlt_stg   <= 8'h00;
      rat_stg   <= 8'h00;
    end else if (wr_hit) begin
      case (offs)
        OFS_POS_LO: pos_stg   <= bus_wdata;
        OFS_POS_HI: pos_cmd   <= {bus_wdata, pos_stg};
        OFS_FRQ_LO: frq_stg   <= bus_wdata;
        OFS_FRQ_HI: freq_cmd  <= {bus_wdata, frq_stg};
        OFS_VLT_LO: vlt_stg   <= bus_wdata;
        OFS_VLT_HI: begin
          volt_cmd <= {bus_wdata, vlt_stg};
          exc_en   <= |{bus_wdata, vlt_stg};
        end
        OFS_RAT_LO: rat_stg   <= bus_wdata;
        OFS_RAT_HI: ratio_cmd <= {bus_wdata, rat_stg};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 8'h00;
      held_q <= 1'b0;
    end else if (rd_hit && offs == OFS_WRP_HI) begin
      hold_q <= wrap_val[7:0];
      held_q <= 1'b1;
    end else if (rd_hit && offs == OFS_WRP_LO) begin
      held_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (hit) begin
      case (offs)
        OFS_POS_LO: bus_rdata = pos_cmd[7:0];
        OFS_POS_HI: bus_rdata = pos_cmd[15:8];
        OFS_WRP_LO: bus_rdata = held_q ? hold_q : wrap_val[7:0];
        OFS_WRP_HI: bus_rdata = wrap_val[15:8];
        OFS_ACC:    bus_rdata = {7'd0, acc_ok};
        OFS_FRQ_LO: bus_rdata = freq_cmd[7:0];
        OFS_FRQ_HI: bus_rdata = freq_cmd[15:8];
        OFS_VLT_LO: bus_rdata = volt_cmd[7:0];
        OFS_VLT_HI: bus_rdata = volt_cmd[15:8];
        OFS_RAT_LO: bus_rdata = ratio_cmd[7:0];
        OFS_RAT_HI: bus_rdata = ratio_cmd[15:8];
        OFS_MOD_LO: bus_rdata = MODEL_ID[7:0];
        OFS_MOD_HI: bus_rdata = MODEL_ID[15:8];
        OFS_SER_LO: bus_rdata = SERIAL_NO[7:0];
        OFS_SER_HI: bus_rdata = SERIAL_NO[15:8];
        OFS_DAT_LO: bus_rdata = DATE_CODE[7:0];
        OFS_DAT_HI: bus_rdata = DATE_CODE[15:8];
        OFS_REV_LO: bus_rdata = REV_LEVEL[7:0];
        OFS_REV_HI: bus_rdata = REV_LEVEL[15:8];
        OFS_SIG:    bus_rdata = {6'd0, sig_ok};
        OFS_EXC:    bus_rdata = {7'd0, exc_ok};
        default:    bus_rdata = 8'h00;
      endcase
    end
  end

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |-> (bus_rdata == 8'h00)); // R1

  AST_POS_ONLY_ON_HI: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && offs == OFS_POS_HI) |=> $stable(pos_cmd)); // R3

  AST_CAPTURE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !(rd_hit && (offs == OFS_WRP_LO || offs == OFS_WRP_HI))) |=> $stable(hold_q)); // R5

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable({pos_cmd, freq_cmd, volt_cmd, ratio_cmd, exc_en})); // R8

  AST_EXC_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_en |-> (volt_cmd != 16'h0000)); // R9

endmodule

// File: tb/posio_regs_tb.sv
module posio_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  base_sw = 5'b10110;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] wrap_val = '0;
  logic        acc_ok = 1'b0;
  logic [1:0]  sig_ok = 2'b00;
  logic        exc_ok = 1'b0;
  logic [15:0] pos_cmd, freq_cmd, volt_cmd, ratio_cmd;
  logic        exc_en;

  int checks = 0;
  int errors = 0;
  logic [7:0] rd_b;

  always #2 clk = ~clk;

  posio_regs #(
    .MODEL_ID(16'hBEEF), .SERIAL_NO(16'h1357), .DATE_CODE(16'h2468), .REV_LEVEL(16'h00C3)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .base_sw(base_sw), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wrap_val(wrap_val), .acc_ok(acc_ok), .sig_ok(sig_ok), .exc_ok(exc_ok),
    .pos_cmd(pos_cmd), .freq_cmd(freq_cmd), .volt_cmd(volt_cmd),
    .ratio_cmd(ratio_cmd), .exc_en(exc_en)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] at(input logic [4:0] o);
    return {base_sw, o};
  endfunction

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    check("R2 pos", pos_cmd, 16'h0000);
    check("R2 freq", freq_cmd, 16'd360);
    check("R2 volt", volt_cmd, 16'h0000);
    check("R2 ratio", ratio_cmd, 16'h0000);
    check("R2 exc_en", {15'd0, exc_en}, 16'h0000);
    rd(at(5'h06), rd_b); check("R4 freq lo after reset", {8'd0, rd_b}, 16'h0068);
    rd(at(5'h07), rd_b); check("R4 freq hi after reset", {8'd0, rd_b}, 16'h0001);
  endtask

  task automatic t_settings;
    wr(at(5'h00), 8'h34);
    check("R3 pos lo staged only", pos_cmd, 16'h0000);
    wr(at(5'h01), 8'h12);
    check("R3 pos commit", pos_cmd, 16'h1234);
    wr(at(5'h06), 8'h90);
    check("R3 freq lo staged only", freq_cmd, 16'd360);
    wr(at(5'h07), 8'h01);
    check("R3 freq 400 Hz", freq_cmd, 16'd400);
    wr(at(5'h0A), 8'hCD);
    wr(at(5'h0B), 8'hAB);
    check("R3 ratio commit", ratio_cmd, 16'hABCD);
    rd(at(5'h00), rd_b); check("R4 pos lo", {8'd0, rd_b}, 16'h0034);
    rd(at(5'h01), rd_b); check("R4 pos hi", {8'd0, rd_b}, 16'h0012);
    rd(at(5'h0B), rd_b); check("R4 ratio hi", {8'd0, rd_b}, 16'h00AB);
  endtask

  task automatic t_decode;
    wr({~base_sw, 5'h00}, 8'h77);
    wr({~base_sw, 5'h01}, 8'h66);
    check("R1 miss write ignored", pos_cmd, 16'h1234);
    rd({base_sw ^ 5'b00001, 5'h07}, rd_b);
    check("R1 miss read zero", {8'd0, rd_b}, 16'h0000);
  endtask

  task automatic t_wrap;
    wrap_val = 16'hA55A;
    rd(at(5'h03), rd_b); check("R5 wrap hi", {8'd0, rd_b}, 16'h00A5);
    wrap_val = 16'h1234;
    rd(at(5'h02), rd_b); check("R5 wrap lo held", {8'd0, rd_b}, 16'h005A);
    rd(at(5'h02), rd_b); check("R5 wrap lo live after release", {8'd0, rd_b}, 16'h0034);
    wrap_val = 16'h9876;
    rd(at(5'h02), rd_b); check("R5 wrap lo live no capture", {8'd0, rd_b}, 16'h0076);
  endtask

  task automatic t_status;
    acc_ok = 1'b1; sig_ok = 2'b10; exc_ok = 1'b0;
    rd(at(5'h04), rd_b); check("R6 accuracy", {8'd0, rd_b}, 16'h0001);
    rd(at(5'h16), rd_b); check("R6 signal", {8'd0, rd_b}, 16'h0002);
    rd(at(5'h18), rd_b); check("R6 excitation low", {8'd0, rd_b}, 16'h0000);
    exc_ok = 1'b1; sig_ok = 2'b01;
    rd(at(5'h18), rd_b); check("R6 excitation high", {8'd0, rd_b}, 16'h0001);
    rd(at(5'h16), rd_b); check("R6 signal other", {8'd0, rd_b}, 16'h0001);
  endtask

  task automatic t_ident;
    rd(at(5'h0C), rd_b); check("R7 model lo", {8'd0, rd_b}, 16'h00EF);
    rd(at(5'h0D), rd_b); check("R7 model hi", {8'd0, rd_b}, 16'h00BE);
    rd(at(5'h11), rd_b); check("R7 serial hi", {8'd0, rd_b}, 16'h0013);
    rd(at(5'h12), rd_b); check("R7 date lo", {8'd0, rd_b}, 16'h0068);
    rd(at(5'h14), rd_b); check("R7 rev lo", {8'd0, rd_b}, 16'h00C3);
  endtask

  task automatic t_readonly;
    wr(at(5'h00), 8'h5E);
    wr(at(5'h02), 8'hF0);
    wr(at(5'h0C), 8'hF1);
    wr(at(5'h05), 8'hF2);
    wr(at(5'h1F), 8'hF3);
    wr(at(5'h16), 8'hF4);
    check("R8 pos untouched", pos_cmd, 16'h1234);
    check("R8 freq untouched", freq_cmd, 16'd400);
    rd(at(5'h0C), rd_b); check("R8 model unchanged", {8'd0, rd_b}, 16'h00EF);
    rd(at(5'h1F), rd_b); check("R8 unmapped read", {8'd0, rd_b}, 16'h0000);
    wr(at(5'h01), 8'h4D);
    check("R8 staged byte kept", pos_cmd, 16'h4D5E);
  endtask

  task automatic t_excite;
    wr(at(5'h08), 8'h05);
    check("R9 no enable before commit", {15'd0, exc_en}, 16'h0000);
    wr(at(5'h09), 8'h01);
    check("R9 volt 26.1", volt_cmd, 16'd261);
    check("R9 enable on", {15'd0, exc_en}, 16'h0001);
    wr(at(5'h08), 8'h00);
    wr(at(5'h09), 8'h00);
    check("R9 enable off", {15'd0, exc_en}, 16'h0000);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_settings();
    t_decode();
    t_wrap();
    t_status();
    t_ident();
    t_readonly();
    t_excite();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule